// File: doc/BRIEF.md
# Paired-Register Block Load Sequencer

This block turns one block-load request into a run of doubleword reads on a 64-bit memory read port. The request gives a byte base address and a 16-bit mask of the registers to load. The chosen registers are handed out in ascending index order and taken two at a time. Each read fetches the words for two registers at once. One cycle later both words go to the register file through two write ports, one word per port. A list of n registers therefore needs ceil(n/2) reads. When n is odd, the final beat fills only one register.

While an operation runs, `busy` stays high, and the surrounding issue logic must not issue anything beside it. The operation takes the whole issue bandwidth, so the next instruction can start only in the cycle after the last write. A one-cycle `done` pulse marks that last write cycle. An empty list finishes in the cycle it is started, with no memory traffic. The memory is assumed to return read data exactly one cycle after each request. The base address is assumed to be doubleword aligned, and its low three bits are ignored.

Top module: `ldm_pair_seq`

## Requirements
- R1: For a non-empty list of n registers, `mem_req` is high for exactly ceil(n/2) consecutive cycles, starting in the cycle where `start` is accepted. The addresses are the base with bits [2:0] cleared, then +8 on each following cycle.
- R2: In the cycle after each read, the k-th pair of listed registers (counting from k=0, ascending index) is written. Port 0 takes the lower index and `mem_rdata[31:0]`. Port 1 takes the next index and `mem_rdata[63:32]`.
- R3: For an odd count, the final write cycle raises `wp0_en` only, and `wp1_en` stays low.
- R4: `done` is high for exactly one cycle, ceil(n/2) cycles after the start cycle, which is the last write cycle.
- R5: `busy` is high from the start cycle through the last write cycle, which is ceil(n/2)+1 cycles, and low otherwise.
- R6: An empty list raises `done` and `busy` only in the start cycle. It raises no `mem_req` and no write enable.
- R7: `start` while `busy` is high from an earlier start is ignored: writes, addresses and timing follow the first request only.
- R8: During and right after reset, `busy`, `done`, `mem_req`, `wp0_en` and `wp1_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a block load (accepted when idle) |
| base_addr | input | 32 | Byte base address |
| reg_list | input | 16 | Bit i set = load register i |
| mem_req | output | 1 | Doubleword read request |
| mem_addr | output | 32 | Aligned byte address of the read |
| mem_rdata | input | 64 | Read data, valid one cycle after the request |
| wp0_en | output | 1 | Write port 0 enable |
| wp0_idx | output | 4 | Write port 0 register index |
| wp0_data | output | 32 | Write port 0 data |
| wp1_en | output | 1 | Write port 1 enable |
| wp1_idx | output | 4 | Write port 1 register index |
| wp1_data | output | 32 | Write port 1 data |
| busy | output | 1 | Operation in progress; issue slots held |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench drives lists with 1 to 8 and 16 registers, lists with wide gaps between bits, single top-bit lists and the empty list. It compares every cycle of each operation with a schedule it derives from its own sorted index list.

Each class of error shows up in its own way:
- An off-by-one in the beat count shows up as an extra or missing read, or as `done` landing a cycle early or late.
- Wrong pairing puts a register on the wrong port or the wrong data half.
- An odd count that is mishandled fires port 1 in the last cycle.
- An empty list that is not special-cased issues a stray read or hangs `busy`.

Starts fired in the middle of an operation must not disturb the schedule.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_STREAM = 2'd1,
    PH_DRAIN  = 2'd2
  } lsm_phase_e;

  // number of set bits in a register mask
  function automatic int unsigned mask_weight(input logic [31:0] m);
    int unsigned c;
    c = 0;
    for (int i = 0; i < 32; i++) c += int'(m[i]);
    return c;
  endfunction

  // number of doubleword beats for n registers
  function automatic int unsigned beats_for(input int unsigned n);
    return (n + 1) / 2;
  endfunction

endpackage

// File: rtl/lsm_reg_picker.sv
module lsm_reg_picker #(
  parameter int NREGS = 16,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic [NREGS-1:0] mask,
  output logic             first_vld,
  output logic [IDX_W-1:0] first_idx,
  output logic             second_vld,
  output logic [IDX_W-1:0] second_idx,
  output logic [NREGS-1:0] rest
);

  // below[i]: number of set bits strictly below i, saturated at 2
  logic [1:0] below [NREGS+1];
  logic [NREGS-1:0] is_first;
  logic [NREGS-1:0] is_second;

  assign below[0] = 2'd0;

  for (genvar i = 0; i < NREGS; i++) begin : g_scan
    assign is_first[i]  = mask[i] && (below[i] == 2'd0);
    assign is_second[i] = mask[i] && (below[i] == 2'd1);
    assign below[i+1]   = (mask[i] && below[i] != 2'd2) ? below[i] + 2'd1 : below[i];
  end

  always_comb begin
    first_idx  = '0;
    second_idx = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (is_first[i])  first_idx  = IDX_W'(i);
      if (is_second[i]) second_idx = IDX_W'(i);
    end
  end

  assign first_vld  = |is_first;
  assign second_vld = |is_second;
  assign rest       = mask & ~(is_first | is_second);

endmodule

// File: rtl/lsm_ctrl.sv
module lsm_ctrl
  import lsm_pkg::*;
#(
  parameter int NREGS     = 16,
  parameter int ADDR_W    = 32,
  parameter int BEAT_BYTES = 8,
  localparam int IDX_W    = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [NREGS-1:0]  reg_list,
  // picker interface
  output logic [NREGS-1:0]  cur_mask,
  input  logic              pk_first_vld,
  input  logic [IDX_W-1:0]  pk_first_idx,
  input  logic              pk_second_vld,
  input  logic [IDX_W-1:0]  pk_second_idx,
  input  logic [NREGS-1:0]  pk_rest,
  // memory side
  output logic              issue,
  output logic [ADDR_W-1:0] beat_addr,
  // write stage
  output logic              wr_phase,
  output logic              pend_a_vld,
  output logic [IDX_W-1:0]  pend_a_idx,
  output logic              pend_b_vld,
  output logic [IDX_W-1:0]  pend_b_idx,
  // status
  output logic              start_acc,
  output logic              empty_done,
  output logic              last_write,
  output logic              busy
);

  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BEAT_BYTES - 1);
  localparam logic [ADDR_W-1:0] STRIDE     = ADDR_W'(BEAT_BYTES);

  lsm_phase_e       phase_q;
  logic [NREGS-1:0] rem_q;
  logic [ADDR_W-1:0] addr_q;
  logic             idle;

  assign idle       = (phase_q == PH_IDLE);
  assign start_acc  = start && idle;
  assign cur_mask   = idle ? reg_list : rem_q;
  assign issue      = (start_acc && (|reg_list)) || (phase_q == PH_STREAM);
  assign beat_addr  = idle ? (base_addr & ALIGN_MASK) : addr_q;
  assign empty_done = start_acc && !(|reg_list);
  assign wr_phase   = !idle;
  assign last_write = (phase_q == PH_DRAIN);
  assign busy       = start_acc || !idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      rem_q      <= '0;
      addr_q     <= '0;
      pend_a_vld <= 1'b0;
      pend_b_vld <= 1'b0;
      pend_a_idx <= '0;
      pend_b_idx <= '0;
    end else if (issue) begin
      rem_q      <= pk_rest;
      addr_q     <= beat_addr + STRIDE;
      pend_a_vld <= pk_first_vld;
      pend_a_idx <= pk_first_idx;
      pend_b_vld <= pk_second_vld;
      pend_b_idx <= pk_second_idx;
      phase_q    <= (|pk_rest) ? PH_STREAM : PH_DRAIN;
    end else if (phase_q == PH_DRAIN) begin
      phase_q    <= PH_IDLE;
      pend_a_vld <= 1'b0;
      pend_b_vld <= 1'b0;
    end
  end

endmodule

// File: rtl/lsm_wr_steer.sv
module lsm_wr_steer #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              wr_phase,
  input  logic              pend_a_vld,
  input  logic [IDX_W-1:0]  pend_a_idx,
  input  logic              pend_b_vld,
  input  logic [IDX_W-1:0]  pend_b_idx,
  input  logic [2*DATA_W-1:0] rdata,
  output logic              wp0_en,
  output logic [IDX_W-1:0]  wp0_idx,
  output logic [DATA_W-1:0] wp0_data,
  output logic              wp1_en,
  output logic [IDX_W-1:0]  wp1_idx,
  output logic [DATA_W-1:0] wp1_data
);

  // lower word feeds the lower-ordered register
  assign wp0_en   = wr_phase && pend_a_vld;
  assign wp0_idx  = pend_a_idx;
  assign wp0_data = rdata[DATA_W-1:0];
  assign wp1_en   = wr_phase && pend_b_vld;
  assign wp1_idx  = pend_b_idx;
  assign wp1_data = rdata[2*DATA_W-1:DATA_W];

endmodule

// File: rtl/ldm_pair_seq.sv
module ldm_pair_seq #(
  parameter int NREGS  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NREGS),
  localparam int BEAT_BYTES = (2 * DATA_W) / 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [NREGS-1:0]    reg_list,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic [2*DATA_W-1:0] mem_rdata,
  output logic                wp0_en,
  output logic [IDX_W-1:0]    wp0_idx,
  output logic [DATA_W-1:0]   wp0_data,
  output logic                wp1_en,
  output logic [IDX_W-1:0]    wp1_idx,
  output logic [DATA_W-1:0]   wp1_data,
  output logic                busy,
  output logic                done
);

  logic [NREGS-1:0] cur_mask;
  logic             pk_first_vld, pk_second_vld;
  logic [IDX_W-1:0] pk_first_idx, pk_second_idx;
  logic [NREGS-1:0] pk_rest;
  logic             wr_phase;
  logic             pend_a_vld, pend_b_vld;
  logic [IDX_W-1:0] pend_a_idx, pend_b_idx;
  logic             start_acc, empty_done, last_write;

  lsm_reg_picker #(.NREGS(NREGS)) u_pick (
    .mask       (cur_mask),
    .first_vld  (pk_first_vld),
    .first_idx  (pk_first_idx),
    .second_vld (pk_second_vld),
    .second_idx (pk_second_idx),
    .rest       (pk_rest)
  );

  lsm_ctrl #(.NREGS(NREGS), .ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .base_addr     (base_addr),
    .reg_list      (reg_list),
    .cur_mask      (cur_mask),
    .pk_first_vld  (pk_first_vld),
    .pk_first_idx  (pk_first_idx),
    .pk_second_vld (pk_second_vld),
    .pk_second_idx (pk_second_idx),
    .pk_rest       (pk_rest),
    .issue         (mem_req),
    .beat_addr     (mem_addr),
    .wr_phase      (wr_phase),
    .pend_a_vld    (pend_a_vld),
    .pend_a_idx    (pend_a_idx),
    .pend_b_vld    (pend_b_vld),
    .pend_b_idx    (pend_b_idx),
    .start_acc     (start_acc),
    .empty_done    (empty_done),
    .last_write    (last_write),
    .busy          (busy)
  );

  lsm_wr_steer #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_steer (
    .wr_phase   (wr_phase),
    .pend_a_vld (pend_a_vld),
    .pend_a_idx (pend_a_idx),
    .pend_b_vld (pend_b_vld),
    .pend_b_idx (pend_b_idx),
    .rdata      (mem_rdata),
    .wp0_en     (wp0_en),
    .wp0_idx    (wp0_idx),
    .wp0_data   (wp0_data),
    .wp1_en     (wp1_en),
    .wp1_idx    (wp1_idx),
    .wp1_data   (wp1_data)
  );

  assign done = empty_done || last_write;

endmodule

// File: rtl/lsm_checker.sv
module lsm_checker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int BEAT_BYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              wp0_en,
  input logic [IDX_W-1:0]  wp0_idx,
  input logic              wp1_en,
  input logic [IDX_W-1:0]  wp1_idx
);

  localparam int AL = $clog2(BEAT_BYTES);

  // R1
  req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[AL-1:0] == '0));

  // R1
  beat_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(BEAT_BYTES)));

  // R2
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp0_en || wp1_en) |-> $past(mem_req));

  // R2
  port_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp1_en |-> (wp0_en && (wp1_idx > wp0_idx)));

  // R5
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || wp0_en) |-> busy);

  // R4
  done_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy || start));

  // R3
  done_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wp0_en) |-> !mem_req);

endmodule

bind ldm_pair_seq lsm_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BEAT_BYTES(BEAT_BYTES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .mem_req  (mem_req),
  .mem_addr (mem_addr),
  .wp0_en   (wp0_en),
  .wp0_idx  (wp0_idx),
  .wp1_en   (wp1_en),
  .wp1_idx  (wp1_idx)
);

// File: tb/sim_ldm_pair_seq.sv
`timescale 1ns/1ps
module sim_ldm_pair_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [15:0] reg_list = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [63:0] mem_rdata = '0;
  logic        wp0_en, wp1_en, busy, done;
  logic [3:0]  wp0_idx, wp1_idx;
  logic [31:0] wp0_data, wp1_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ldm_pair_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .reg_list(reg_list), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .wp0_en(wp0_en), .wp0_idx(wp0_idx),
    .wp0_data(wp0_data), .wp1_en(wp1_en), .wp1_idx(wp1_idx),
    .wp1_data(wp1_data), .busy(busy), .done(done)
  );

  function automatic logic [63:0] mem_word(input logic [31:0] a);
    return {a ^ 32'h5A3C_0F96, ~(a * 32'd3)};
  endfunction

  // memory: one-cycle read latency
  always @(posedge clk) if (mem_req) mem_rdata <= mem_word(mem_addr);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // run one operation; if poke, fire a stray start with another list in cycle 1
  task automatic run_op(input logic [31:0] base, input logic [15:0] lst, input bit poke);
    int ord [16];
    int n;
    int nb;
    logic [31:0] b8;
    n = 0;
    for (int i = 0; i < 16; i++) if (lst[i]) begin ord[n] = i; n++; end
    nb = (n + 1) / 2;
    b8 = base & 32'hFFFF_FFF8;
    @(posedge clk); #1;
    start = 1'b1; base_addr = base; reg_list = lst;
    for (int c = 0; c <= nb + 1; c++) begin
      @(negedge clk);
      // R1 reads
      chk(mem_req == (c < nb), "R1 mem_req", 64'(mem_req), 64'(c < nb));
      if (c < nb) chk(mem_addr == b8 + 32'(8 * c), "R1 mem_addr", 64'(mem_addr), 64'(b8 + 32'(8 * c)));
      // R2/R3 writes
      if (c >= 1 && c <= nb) begin
        logic [63:0] w;
        int k;
        k = 2 * (c - 1);
        w = mem_word(b8 + 32'(8 * (c - 1)));
        chk(wp0_en && wp0_idx == 4'(ord[k]) && wp0_data == w[31:0], "R2 port0",
            {wp0_en, 27'd0, wp0_idx, wp0_data}, {1'b1, 27'd0, 4'(ord[k]), w[31:0]});
        if (k + 1 < n)
          chk(wp1_en && wp1_idx == 4'(ord[k+1]) && wp1_data == w[63:32], "R2 port1",
              {wp1_en, 27'd0, wp1_idx, wp1_data}, {1'b1, 27'd0, 4'(ord[k+1]), w[63:32]});
        else
          chk(!wp1_en, "R3 odd tail port1", 64'(wp1_en), 64'd0);
      end else begin
        chk(!wp0_en && !wp1_en, "R6 no write", {wp0_en, wp1_en}, 64'd0);
      end
      // R4/R6 done, R5 busy
      chk(done == (c == nb), (n == 0) ? "R6 done" : "R4 done", 64'(done), 64'(c == nb));
      chk(busy == (c <= nb), (n == 0) ? "R6 busy" : "R5 busy", 64'(busy), 64'(c <= nb));
      @(posedge clk); #1;
      // R7 stray start while busy
      start = (poke && c == 0 && nb > 0);
      if (start) begin base_addr = ~base; reg_list = ~lst; end
      if (c >= nb) start = 1'b0;
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    chk(!busy && !done && !mem_req && !wp0_en && !wp1_en, "R8 reset",
        {busy, done, mem_req, wp0_en, wp1_en}, 64'd0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_req, "R8 after reset", {busy, done, mem_req}, 64'd0);
    // directed counts 1..8
    for (int n = 1; n <= 8; n++) run_op(32'h1000_0040 + 32'(n * 64), 16'((1 << n) - 1), 1'b0);
    run_op(32'h0000_0100, 16'h0000, 1'b0);   // R6
    run_op(32'h0000_0207, 16'hFFFF, 1'b0);   // R1 low bits ignored
    run_op(32'h0000_0300, 16'h8001, 1'b0);   // R2 wide gap
    run_op(32'h0000_0400, 16'h8000, 1'b0);   // R3 single top register
    run_op(32'h0000_0500, 16'h0155, 1'b1);   // R7 stray start
    run_op(32'h0000_0600, 16'h0000, 1'b0);   // R6 back to back
    // random
    for (int t = 0; t < 60; t++) begin
      logic [15:0] l;
      l = 16'($urandom);
      if (t % 3 == 0) l = l & 16'($urandom);
      run_op($urandom, l, (t % 4) == 1);
      repeat ($urandom % 3) begin
        @(negedge clk);
        chk(!busy && !done && !mem_req, "R5 idle gap", {busy, done, mem_req}, 64'd0);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule